// File: doc/BRIEF.md
# Virtual Channel Input Controller

This block sits on one input port of a wormhole router whose physical link carries several virtual channels (VCs). Every incoming flit carries a VC number and a two-bit kind. The flit is written into a small FIFO owned by that VC. Each VC runs its own four-state machine. A head flit at the front of an idle VC starts a packet. The VC then asks an external route unit for an output port and an external VC allocator for a downstream VC. Once it holds both, it bids for the crossbar on every cycle in which it has a flit buffered.

A switch grant stands for one downstream buffer slot plus one cycle of link bandwidth. On that grant the front flit leaves at once, labelled with the port and downstream VC recorded for the packet. Only the head flit obtains route and output-VC state. Body and tail flits reuse the state recorded for their head, so after the head they only need switch grants. When the tail leaves, the VC goes back to idle.

Because each VC has its own storage and state, a packet stalled on one VC does not hold up a packet on another VC of the same link.

Top module: `vc_input_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, every VC reads idle on vc_state_o, all request vectors and out_valid_o are 0, and overflow_o is 0. The state code is 00 idle, 01 routing, 10 waiting for output VC, 11 active, with VC v at bits [2v+1:2v].
- R2: Flit kinds are coded with bit 0 = head and bit 1 = tail: 01 head, 00 body, 10 tail, 11 single-flit packet. When a head or single flit is written into an empty idle VC, that VC reads routing and raises its route_req_o bit after the second rising edge.
- R3: A route result (route_valid_i with route_vc_i naming a VC in routing state) stores route_port_i. On the next edge the VC moves to waiting, drops route_req_o and raises its vca_req_o bit.
- R4: A vca_gnt_i bit for a waiting VC stores vca_ovc_i. On the next edge the VC moves to active. An active VC drives its sa_req_o bit high exactly when its FIFO holds a flit.
- R5: In any cycle where an active, non-empty VC has its sa_gnt_i bit set, out_valid_o is 1 in that same cycle. The output then carries the front flit's kind and data, the VC number, and the port and output VC stored for the packet. Body and tail flits leave with the same port and output VC as their head.
- R6: The edge on which a tail or single flit leaves returns its VC to idle. If the next flit in that FIFO is a head, the VC re-enters routing one edge later.
- R7: Each VC holds up to 4 flits and delivers them in arrival order, across packet boundaries.
- R8: A VC that is active but never granted keeps its state and its flits, while a packet on another VC completes fully.
- R9: A flit that arrives for a VC whose FIFO is full, in a cycle where that VC does not send, is dropped and sets overflow_o, which stays 1 until reset. If the full VC does send in that same cycle, the arriving flit is stored and overflow_o is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flit_valid_i | input | 1 | Incoming flit present |
| flit_type_i | input | 2 | Flit kind (bit 0 head, bit 1 tail) |
| flit_vc_i | input | 2 | VC the flit belongs to |
| flit_data_i | input | 16 | Flit payload |
| route_req_o | output | 4 | Per-VC request for a route result |
| route_valid_i | input | 1 | Route result present |
| route_vc_i | input | 2 | VC the route result is for |
| route_port_i | input | 2 | Output port chosen for the packet |
| vca_req_o | output | 4 | Per-VC request for an output VC |
| vca_gnt_i | input | 4 | Per-VC output-VC grant |
| vca_ovc_i | input | 2 | Output VC granted |
| sa_req_o | output | 4 | Per-VC switch request |
| sa_gnt_i | input | 4 | Per-VC switch grant, one-hot or zero |
| out_valid_o | output | 1 | Flit leaving this cycle |
| out_type_o | output | 2 | Kind of leaving flit |
| out_data_o | output | 16 | Payload of leaving flit |
| out_vc_o | output | 2 | Input VC of leaving flit |
| out_port_o | output | 2 | Output port of leaving flit |
| out_ovc_o | output | 2 | Output VC of leaving flit |
| vc_state_o | output | 8 | Per-VC state, 2 bits each |
| overflow_o | output | 1 | Sticky FIFO overflow flag |

## Verification
The test targets two pairs of events that can coincide on one VC. The first pair is a write into a full FIFO and a switch-granted read in the same cycle. The bench fills VC3 with four flits, then drives a tail flit and the VC3 switch grant together. It expects the tail to be stored, overflow_o to stay 0, and the tail to be delivered fifth. The second pair is a tail leaving while the next packet's head is already queued behind it. For this, VC2 is loaded with two back-to-back packets, and its state is sampled just after the tail leaves (idle) and one edge later (routing). Every departing flit is compared against a per-VC scoreboard queue together with the port and output VC the bench expects.

// File: rtl/vcic_pkg.sv
package vcic_pkg;
  typedef enum logic [1:0] {
    VC_IDLE    = 2'b00,
    VC_ROUTING = 2'b01,
    VC_WAIT_VC = 2'b10,
    VC_ACTIVE  = 2'b11
  } vc_state_e;

  localparam int KIND_W   = 2;
  localparam int HEAD_BIT = 0;
  localparam int TAIL_BIT = 1;
endpackage

// File: rtl/vcic_fifo.sv
module vcic_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] din_i,
  input  logic         rd_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_rd   = rd_i && !empty_o;
  // a full FIFO still accepts when it sends in the same cycle
  assign do_wr   = wr_i && (!full_o || do_rd);
  assign drop_o  = wr_i && !do_wr;
  assign dout_o  = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= nxt(wp_q);
      if (do_rd) rp_q <= nxt(rp_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q] <= din_i;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i) |=> full_o); // R9
endmodule

// File: rtl/vcic_vc_fsm.sv
module vcic_vc_fsm
  import vcic_pkg::*;
#(
  parameter int PORT_W = 2,
  parameter int OVC_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              front_valid_i,
  input  logic [KIND_W-1:0] front_kind_i,
  input  logic              route_ld_i,
  input  logic [PORT_W-1:0] route_port_i,
  input  logic              vca_gnt_i,
  input  logic [OVC_W-1:0]  vca_ovc_i,
  input  logic              pop_i,
  output vc_state_e         state_o,
  output logic [PORT_W-1:0] port_o,
  output logic [OVC_W-1:0]  ovc_o,
  output logic              route_req_o,
  output logic              vca_req_o,
  output logic              sa_req_o
);
  vc_state_e         state_q, state_d;
  logic [PORT_W-1:0] port_q;
  logic [OVC_W-1:0]  ovc_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      VC_IDLE:    if (front_valid_i && front_kind_i[HEAD_BIT]) state_d = VC_ROUTING;
      VC_ROUTING: if (route_ld_i) state_d = VC_WAIT_VC;
      VC_WAIT_VC: if (vca_gnt_i)  state_d = VC_ACTIVE;
      VC_ACTIVE:  if (pop_i && front_kind_i[TAIL_BIT]) state_d = VC_IDLE;
      default:    state_d = VC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= VC_IDLE;
      port_q  <= '0;
      ovc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == VC_ROUTING && route_ld_i) port_q <= route_port_i;
      if (state_q == VC_WAIT_VC && vca_gnt_i)  ovc_q  <= vca_ovc_i;
    end
  end

  assign state_o     = state_q;
  assign port_o      = port_q;
  assign ovc_o       = ovc_q;
  assign route_req_o = (state_q == VC_ROUTING);
  assign vca_req_o   = (state_q == VC_WAIT_VC);
  assign sa_req_o    = (state_q == VC_ACTIVE) && front_valid_i;

  AST_TAIL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && front_kind_i[TAIL_BIT]) |=> (state_q == VC_IDLE)); // R6
  AST_ACTIVE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == VC_ACTIVE) |-> ($past(state_q) == VC_WAIT_VC)); // R4
  AST_ROUTE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == VC_ACTIVE && $past(state_q) == VC_ACTIVE) |-> ($stable(port_q) && $stable(ovc_q))); // R5
endmodule

// File: rtl/vc_input_ctrl.sv
module vc_input_ctrl
  import vcic_pkg::*;
#(
  parameter int  NUM_VC = 4,
  parameter int  DEPTH  = 4,
  parameter int  DATA_W = 16,
  parameter int  PORT_W = 2,
  parameter int  OVC_W  = 2,
  localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flit_valid_i,
  input  logic [KIND_W-1:0]   flit_type_i,
  input  logic [VC_W-1:0]     flit_vc_i,
  input  logic [DATA_W-1:0]   flit_data_i,
  output logic [NUM_VC-1:0]   route_req_o,
  input  logic                route_valid_i,
  input  logic [VC_W-1:0]     route_vc_i,
  input  logic [PORT_W-1:0]   route_port_i,
  output logic [NUM_VC-1:0]   vca_req_o,
  input  logic [NUM_VC-1:0]   vca_gnt_i,
  input  logic [OVC_W-1:0]    vca_ovc_i,
  output logic [NUM_VC-1:0]   sa_req_o,
  input  logic [NUM_VC-1:0]   sa_gnt_i,
  output logic                out_valid_o,
  output logic [KIND_W-1:0]   out_type_o,
  output logic [DATA_W-1:0]   out_data_o,
  output logic [VC_W-1:0]     out_vc_o,
  output logic [PORT_W-1:0]   out_port_o,
  output logic [OVC_W-1:0]    out_ovc_o,
  output logic [2*NUM_VC-1:0] vc_state_o,
  output logic                overflow_o
);
  localparam int FW = KIND_W + DATA_W;

  logic [FW-1:0]     front   [NUM_VC];
  logic [PORT_W-1:0] port_v  [NUM_VC];
  logic [OVC_W-1:0]  ovc_v   [NUM_VC];
  logic [NUM_VC-1:0] empty_v, drop_v, pop_v;
  logic              ovf_q;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic      wr, full;
    vc_state_e st;

    assign wr       = flit_valid_i && (flit_vc_i == VC_W'(v));
    assign pop_v[v] = sa_gnt_i[v] && sa_req_o[v];

    vcic_fifo #(.DEPTH(DEPTH), .W(FW)) u_fifo (
      .clk_i, .rst_ni,
      .wr_i    (wr),
      .din_i   ({flit_type_i, flit_data_i}),
      .rd_i    (pop_v[v]),
      .dout_o  (front[v]),
      .empty_o (empty_v[v]),
      .full_o  (full),
      .drop_o  (drop_v[v])
    );

    vcic_vc_fsm #(.PORT_W(PORT_W), .OVC_W(OVC_W)) u_fsm (
      .clk_i, .rst_ni,
      .front_valid_i (!empty_v[v]),
      .front_kind_i  (front[v][FW-1 -: KIND_W]),
      .route_ld_i    (route_valid_i && (route_vc_i == VC_W'(v))),
      .route_port_i  (route_port_i),
      .vca_gnt_i     (vca_gnt_i[v]),
      .vca_ovc_i     (vca_ovc_i),
      .pop_i         (pop_v[v]),
      .state_o       (st),
      .port_o        (port_v[v]),
      .ovc_o         (ovc_v[v]),
      .route_req_o   (route_req_o[v]),
      .vca_req_o     (vca_req_o[v]),
      .sa_req_o      (sa_req_o[v])
    );

    assign vc_state_o[2*v +: 2] = st;

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sa_gnt_i[v] |-> (st == VC_ACTIVE && !empty_v[v])); // R4
    AST_DROP_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_v[v] |-> (full && !pop_v[v])); // R9
  end

  always_comb begin
    out_valid_o = 1'b0;
    out_type_o  = '0;
    out_data_o  = '0;
    out_vc_o    = '0;
    out_port_o  = '0;
    out_ovc_o   = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (pop_v[v]) begin
        out_valid_o = 1'b1;
        out_type_o  = front[v][FW-1 -: KIND_W];
        out_data_o  = front[v][DATA_W-1:0];
        out_vc_o    = VC_W'(v);
        out_port_o  = port_v[v];
        out_ovc_o   = ovc_v[v];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (|drop_v)   ovf_q <= 1'b1;
  end
  assign overflow_o = ovf_q;

  AST_SA_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sa_gnt_i)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(overflow_o) |-> overflow_o); // R9
endmodule

// File: tb/vc_input_ctrl_test.sv
`timescale 1ns/1ps
module vc_input_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flit_valid = 1'b0;
  logic [1:0]  flit_type = '0;
  logic [1:0]  flit_vc = '0;
  logic [15:0] flit_data = '0;
  logic [3:0]  route_req, vca_req, sa_req;
  logic        route_valid = 1'b0;
  logic [1:0]  route_vc = '0, route_port = '0;
  logic [3:0]  vca_gnt = '0, sa_gnt = '0;
  logic [1:0]  vca_ovc = '0;
  logic        out_valid;
  logic [1:0]  out_type, out_vc, out_port, out_ovc;
  logic [15:0] out_data;
  logic [7:0]  vc_state;
  logic        overflow;

  int total = 0, bad = 0;
  logic [17:0] exp_q [4][$];
  logic [1:0]  exp_port [4];
  logic [1:0]  exp_ovc  [4];

  always #10 clk = ~clk;

  vc_input_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .flit_valid_i(flit_valid), .flit_type_i(flit_type), .flit_vc_i(flit_vc), .flit_data_i(flit_data),
    .route_req_o(route_req), .route_valid_i(route_valid), .route_vc_i(route_vc), .route_port_i(route_port),
    .vca_req_o(vca_req), .vca_gnt_i(vca_gnt), .vca_ovc_i(vca_ovc),
    .sa_req_o(sa_req), .sa_gnt_i(sa_gnt),
    .out_valid_o(out_valid), .out_type_o(out_type), .out_data_o(out_data), .out_vc_o(out_vc),
    .out_port_o(out_port), .out_ovc_o(out_ovc), .vc_state_o(vc_state), .overflow_o(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] st(input int v);
    return vc_state[2*v +: 2];
  endfunction

  // monitor: compares every departing flit with the scoreboard
  always begin
    @(negedge clk); #5;
    if (rst_n && out_valid) begin
      if (exp_q[out_vc].size() == 0) begin
        chk(0, "R7 unexpected flit", {14'd0, out_type, out_data}, 0);
      end else begin
        logic [17:0] e;
        e = exp_q[out_vc].pop_front();
        chk({out_type, out_data} == e, "R7 order/data", {14'd0, out_type, out_data}, {14'd0, e});
        chk(out_port == exp_port[out_vc], "R5 port", out_port, exp_port[out_vc]);
        chk(out_ovc == exp_ovc[out_vc], "R5 ovc", out_ovc, exp_ovc[out_vc]);
      end
    end
  end

  task automatic send(input int v, input logic [1:0] t, input logic [15:0] d, input bit keep);
    @(negedge clk);
    flit_valid = 1'b1; flit_vc = 2'(v); flit_type = t; flit_data = d;
    if (keep) exp_q[v].push_back({t, d});
    @(negedge clk);
    flit_valid = 1'b0;
  endtask

  task automatic do_route(input int v, input logic [1:0] p);
    @(negedge clk);
    route_valid = 1'b1; route_vc = 2'(v); route_port = p; exp_port[v] = p;
    @(negedge clk);
    route_valid = 1'b0;
  endtask

  task automatic do_vca(input int v, input logic [1:0] o);
    @(negedge clk);
    vca_gnt = 4'b1 << v; vca_ovc = o; exp_ovc[v] = o;
    @(negedge clk);
    vca_gnt = '0;
  endtask

  task automatic do_sa(input int v);
    @(negedge clk);
    sa_gnt = 4'b1 << v;
    @(negedge clk);
    sa_gnt = '0;
  endtask

  task automatic send_and_sa(input int v, input logic [1:0] t, input logic [15:0] d);
    @(negedge clk);
    flit_valid = 1'b1; flit_vc = 2'(v); flit_type = t; flit_data = d;
    exp_q[v].push_back({t, d});
    sa_gnt = 4'b1 << v;
    @(negedge clk);
    flit_valid = 1'b0; sa_gnt = '0;
  endtask

  task automatic settle();
    #5;
  endtask

  initial begin
    #(200000 * 20);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk(vc_state == 8'h00 && route_req == 0 && vca_req == 0 && sa_req == 0, "R1 reset state", vc_state, 0);
    chk(!out_valid && !overflow, "R1 reset outputs", {out_valid, overflow}, 0);
    @(negedge clk); rst_n = 1'b1;
    #5;
    chk(vc_state == 8'h00 && route_req == 0 && !out_valid, "R1 after release", vc_state, 0);

    // single-flit packet on VC0 through every state
    send(0, 2'b11, 16'h5A01, 1);
    @(negedge clk); settle();
    chk(st(0) == 2'b01 && route_req == 4'b0001, "R2 routing", {st(0), route_req}, {2'b01, 4'b0001});
    do_route(0, 2'd2); settle();
    chk(st(0) == 2'b10 && vca_req == 4'b0001 && route_req == 0, "R3 wait vc", {st(0), vca_req}, {2'b10, 4'b0001});
    do_vca(0, 2'd3); settle();
    chk(st(0) == 2'b11 && sa_req == 4'b0001 && vca_req == 0, "R4 active", {st(0), sa_req}, {2'b11, 4'b0001});
    do_sa(0); settle();
    chk(st(0) == 2'b00 && sa_req == 0, "R6 single released", st(0), 0);

    // 4-flit packet on VC1, body/tail inherit head route
    send(1, 2'b01, 16'h1100, 1);
    send(1, 2'b00, 16'h1101, 1);
    send(1, 2'b00, 16'h1102, 1);
    send(1, 2'b10, 16'h1103, 1);
    do_route(1, 2'd1);
    do_vca(1, 2'd0);
    for (int i = 0; i < 3; i++) begin
      do_sa(1); settle();
      chk(st(1) == 2'b11, "R5 body keeps route", st(1), 2'b11);
    end
    do_sa(1); settle();
    chk(st(1) == 2'b00 && sa_req[1] == 1'b0, "R6 tail released", st(1), 0);

    // write and send together on a full VC3
    send(3, 2'b01, 16'h3300, 1);
    send(3, 2'b00, 16'h3301, 1);
    send(3, 2'b00, 16'h3302, 1);
    send(3, 2'b00, 16'h3303, 1);
    do_route(3, 2'd0);
    do_vca(3, 2'd1);
    send_and_sa(3, 2'b10, 16'h3304); settle();
    chk(overflow == 1'b0, "R9 full write with read", overflow, 0);
    for (int i = 0; i < 4; i++) do_sa(3);
    settle();
    chk(st(3) == 2'b00 && exp_q[3].size() == 0, "R7 VC3 drained", st(3), 0);

    // blocked VC0 does not stop VC1
    send(0, 2'b01, 16'h0A00, 1);
    send(0, 2'b10, 16'h0A01, 1);
    do_route(0, 2'd1);
    do_vca(0, 2'd0);
    send(1, 2'b11, 16'h1B00, 1);
    @(negedge clk); settle();
    chk(st(1) == 2'b01 && route_req[1], "R2 VC1 routing", st(1), 2'b01);
    do_route(1, 2'd3);
    do_vca(1, 2'd2);
    do_sa(1); settle();
    chk(st(1) == 2'b00 && exp_q[1].size() == 0, "R8 VC1 done", st(1), 0);
    chk(st(0) == 2'b11 && sa_req[0] && exp_q[0].size() == 2, "R8 VC0 held", st(0), 2'b11);
    do_sa(0); do_sa(0); settle();
    chk(st(0) == 2'b00, "R6 VC0 released", st(0), 0);

    // two packets queued on VC2, then overflow
    send(2, 2'b01, 16'h2200, 1);
    send(2, 2'b00, 16'h2201, 1);
    send(2, 2'b10, 16'h2202, 1);
    send(2, 2'b11, 16'h2203, 1);
    chk(overflow == 1'b0, "R9 no overflow at 4", overflow, 0);
    send(2, 2'b00, 16'hDEAD, 0); settle();
    chk(overflow == 1'b1, "R9 overflow set", overflow, 1);
    do_route(2, 2'd2);
    do_vca(2, 2'd3);
    do_sa(2); do_sa(2); do_sa(2); settle();
    chk(st(2) == 2'b00, "R6 idle after tail", st(2), 0);
    @(negedge clk); settle();
    chk(st(2) == 2'b01, "R6 next head routing", st(2), 2'b01);
    do_route(2, 2'd0);
    do_vca(2, 2'd2);
    do_sa(2); settle();
    chk(st(2) == 2'b00 && sa_req[2] == 1'b0, "R9 dropped flit absent", {st(2), sa_req[2]}, 0);
    chk(overflow == 1'b1, "R9 sticky", overflow, 1);
    for (int v = 0; v < 4; v++)
      chk(exp_q[v].size() == 0, "R7 scoreboard empty", exp_q[v].size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule